// File: doc/BRIEF.md
# PHY Control-Register Handshake Sequencer

This block is a hardware master for the narrow control-register port of a serial PHY. A host issues one of three operations through a small command interface: address capture, data write or data read, each with a 16-bit operand. The sequencer turns the operation into a chain of four-phase request/acknowledge steps. For each step it drives the 16-bit bus and at most one strobe: capture-address, capture-data, write or read. It then waits for the PHY's single acknowledge line to reach the level that step expects.

The acknowledge line passes through a two-flop synchronizer. The block samples it once on entering a step, and then once every `INTERVAL` clock cycles. It gives up after `MAX_RETRY + 1` samples. A failed wait aborts the whole operation: all PHY outputs return to zero and the block pulses `error`. A completed operation pulses `done`. A read latches the PHY status word at the moment the read strobe is acknowledged.

States: `S_IDLE`, `S_ADDR_CAP`, `S_ADDR_REL`, `S_WDAT_CAP`, `S_WDAT_REL`, `S_WSTB_SET`, `S_WSTB_REL`, `S_RSTB_SET` and `S_RSTB_REL`. The transitions are:
- **Accept:** `S_IDLE` moves to `S_ADDR_CAP`, `S_WDAT_CAP` or `S_RSTB_SET`, chosen by the opcode.
- **Step advance:** on a matching acknowledge sample, each state moves to the next one in its chain. These are `S_ADDR_CAP` to `S_ADDR_REL`, `S_WDAT_CAP` to `S_WDAT_REL` to `S_WSTB_SET` to `S_WSTB_REL`, and `S_RSTB_SET` to `S_RSTB_REL`.
- **Completion:** a matching sample in any `*_REL` state that ends its chain returns to `S_IDLE` and pulses `done`.
- **Abort:** an expired wait in any state except `S_IDLE` returns to `S_IDLE` and pulses `error`.

Top module: `phy_cr_seq`

## Requirements
- R1: After reset, `busy`, `done`, `error`, all four strobes, `phy_bus` and `rd_data` are zero.
- R2: Opcode 0 (address) drives `phy_bus` to the operand with `cap_addr` high until the acknowledge is seen high. It then keeps the operand on `phy_bus` with every strobe low until the acknowledge is seen low. Finally it clears `phy_bus` and pulses `done`.
- R3: Opcode 1 (write) runs four phases and then pulses `done`:
  - the operand on `phy_bus` with `cap_data` high, until the acknowledge is high;
  - the operand with every strobe low, until the acknowledge is low;
  - the operand with `wr_stb` high, until the acknowledge is high;
  - `phy_bus` zero with every strobe low, until the acknowledge is low.
- R4: Opcode 2 (read) raises only `rd_stb`, with `phy_bus` zero. When the acknowledge is seen high, `rd_data` captures `phy_status`. `rd_stb` then drops, and `done` pulses once the acknowledge is low. `rd_data` changes at no other time, including after a failed read.
- R5: Each acknowledge wait samples the synchronized acknowledge on the first cycle of its step, then every `INTERVAL` cycles, for at most `MAX_RETRY + 1` samples. If the first step of an operation never sees its level, `error` rises exactly `MAX_RETRY*INTERVAL + 1` cycles after `busy` rises.
- R6: A timeout in any step aborts the operation. In the cycle `error` is high, `busy` is low and every strobe and `phy_bus` are zero, and no later step of that operation runs.
- R7: `busy` is high from the cycle after a command is accepted until the cycle `done` or `error` rises. A command presented while `busy` is high is ignored, and so is opcode 3.
- R8: At most one of `cap_addr`, `cap_data`, `wr_stb` and `rd_stb` is high in any cycle.
- R9: `done` and `error` are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, sampled while idle |
| cmd_op | input | 2 | 0 address, 1 write, 2 read, 3 no operation |
| cmd_operand | input | 16 | Address or write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | One-cycle acknowledge-timeout pulse |
| rd_data | output | 16 | Last captured PHY status word |
| phy_bus | output | 16 | Address/data bus to the PHY |
| cap_addr | output | 1 | Capture-address strobe |
| cap_data | output | 1 | Capture-data strobe |
| wr_stb | output | 1 | Write strobe |
| rd_stb | output | 1 | Read strobe |
| phy_ack | input | 1 | Asynchronous acknowledge from the PHY |
| phy_status | input | 16 | PHY status word, valid while acknowledging a read |

## Verification
The bench builds the sequencer with `INTERVAL = 4` and `MAX_RETRY = 3`. That shrinks a full timeout from over two million cycles to thirteen. With it, the exact sampling schedule can be checked cycle by cycle: the first failed step, a failure in a release step with the acknowledge stuck high, and normal completion after an early missed sample. A bench PHY model follows the strobes with a selectable mode (responsive, dead or stuck high), and the bench records each change of bus and strobe for comparison with the expected phase order.

// File: rtl/phy_cr_pkg.sv
package phy_cr_pkg;

    typedef enum logic [1:0] {
        OP_ADDR  = 2'd0,
        OP_WRITE = 2'd1,
        OP_READ  = 2'd2,
        OP_NONE  = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR_CAP,
        S_ADDR_REL,
        S_WDAT_CAP,
        S_WDAT_REL,
        S_WSTB_SET,
        S_WSTB_REL,
        S_RSTB_SET,
        S_RSTB_REL
    } state_e;

endpackage

// File: rtl/phy_cr_ack_sync.sv
module phy_cr_ack_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic sync_o
);

    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_i};
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/phy_cr_wait_timer.sv
module phy_cr_wait_timer #(
    parameter int INTERVAL  = 25000,
    parameter int MAX_RETRY = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic restart_i,
    input  logic ack_i,
    input  logic ack_exp_i,
    output logic hit_o,
    output logic expire_o
);

    localparam int IW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam int CW = $clog2(MAX_RETRY + 1) + 1;

    logic [IW-1:0] ivl_q;
    logic [CW-1:0] chk_q;
    logic          sample;
    logic          level_ok;

    assign sample   = active_i && (ivl_q == '0);
    assign level_ok = (ack_i == ack_exp_i);
    assign hit_o    = sample && level_ok;
    assign expire_o = sample && !level_ok && (chk_q == CW'(MAX_RETRY));

    always_ff @(posedge clk) begin
        if (!rst_n || restart_i) begin
            ivl_q <= '0;
            chk_q <= '0;
        end else if (active_i) begin
            if (sample) begin
                ivl_q <= IW'(INTERVAL - 1);
                chk_q <= chk_q + 1'b1;
            end else begin
                ivl_q <= ivl_q - 1'b1;
            end
        end
    end

    // R5: never more than MAX_RETRY+1 samples in one step
    a_r5_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
        chk_q <= CW'(MAX_RETRY));

    // R5: after a missed sample the next one is INTERVAL cycles away
    a_r5_interval_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (sample && !level_ok && !expire_o && !restart_i) |=> (ivl_q == IW'(INTERVAL - 1)));

endmodule

// File: rtl/phy_cr_seq.sv
module phy_cr_seq
    import phy_cr_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int INTERVAL  = 25000,
    parameter int MAX_RETRY = 100,
    parameter int SYNC_FF   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_operand,
    output logic              busy,
    output logic              done,
    output logic              error,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] phy_bus,
    output logic              cap_addr,
    output logic              cap_data,
    output logic              wr_stb,
    output logic              rd_stb,
    input  logic              phy_ack,
    input  logic [DATA_W-1:0] phy_status
);

    state_e            state_q, state_d;
    op_e               op_in;
    logic [DATA_W-1:0] operand_q;
    logic [DATA_W-1:0] rd_data_q;
    logic              done_q, error_q;
    logic              ack_s, ack_exp;
    logic              accept, hit, expire, active, last_step;

    assign op_in  = op_e'(cmd_op);
    assign active = (state_q != S_IDLE);
    assign accept = !active && cmd_valid && (op_in != OP_NONE);

    phy_cr_ack_sync #(.STAGES(SYNC_FF)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (phy_ack),
        .sync_o  (ack_s)
    );

    phy_cr_wait_timer #(.INTERVAL(INTERVAL), .MAX_RETRY(MAX_RETRY)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (active),
        .restart_i (accept || hit || expire),
        .ack_i     (ack_s),
        .ack_exp_i (ack_exp),
        .hit_o     (hit),
        .expire_o  (expire)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == S_IDLE) begin
            if (accept) begin
                unique case (op_in)
                    OP_ADDR:  state_d = S_ADDR_CAP;
                    OP_WRITE: state_d = S_WDAT_CAP;
                    default:  state_d = S_RSTB_SET;
                endcase
            end
        end else if (expire) begin
            state_d = S_IDLE;
        end else if (hit) begin
            unique case (state_q)
                S_ADDR_CAP: state_d = S_ADDR_REL;
                S_WDAT_CAP: state_d = S_WDAT_REL;
                S_WDAT_REL: state_d = S_WSTB_SET;
                S_WSTB_SET: state_d = S_WSTB_REL;
                S_RSTB_SET: state_d = S_RSTB_REL;
                default:    state_d = S_IDLE;
            endcase
        end
    end

    assign last_step = (state_q == S_ADDR_REL) || (state_q == S_WSTB_REL) ||
                       (state_q == S_RSTB_REL);

    // state and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= S_IDLE;
            operand_q <= '0;
            rd_data_q <= '0;
            done_q    <= 1'b0;
            error_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= hit && last_step;
            error_q <= expire;
            if (accept) begin
                operand_q <= cmd_operand;
            end
            if (hit && (state_q == S_RSTB_SET)) begin
                rd_data_q <= phy_status;
            end
        end
    end

    // PHY-side outputs per state
    always_comb begin
        phy_bus  = '0;
        cap_addr = 1'b0;
        cap_data = 1'b0;
        wr_stb   = 1'b0;
        rd_stb   = 1'b0;
        ack_exp  = 1'b0;
        unique case (state_q)
            S_ADDR_CAP: begin phy_bus = operand_q; cap_addr = 1'b1; ack_exp = 1'b1; end
            S_ADDR_REL: begin phy_bus = operand_q; end
            S_WDAT_CAP: begin phy_bus = operand_q; cap_data = 1'b1; ack_exp = 1'b1; end
            S_WDAT_REL: begin phy_bus = operand_q; end
            S_WSTB_SET: begin phy_bus = operand_q; wr_stb = 1'b1; ack_exp = 1'b1; end
            S_RSTB_SET: begin rd_stb = 1'b1; ack_exp = 1'b1; end
            default:    begin end
        endcase
    end

    assign busy    = active;
    assign done    = done_q;
    assign error   = error_q;
    assign rd_data = rd_data_q;

    // R8: strobes mutually exclusive
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cap_addr, cap_data, wr_stb, rd_stb}));

    // R9: done and error are single pulses, never together
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r9_error_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> !error);
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));

    // R6: an abort leaves the PHY side quiet
    a_r6_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!busy && (phy_bus == '0) && !cap_addr && !cap_data && !wr_stb && !rd_stb));

    // R4: read data moves only while the read strobe is up
    a_r4_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(rd_data));

    // R7: a command during busy does not disturb the operand
    a_r7_operand_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(operand_q));

endmodule

// File: tb/test_phy_cr_seq.sv
module test_phy_cr_seq;

    localparam int INTERVAL  = 4;
    localparam int MAX_RETRY = 3;
    localparam int NVEC      = 6;

    // {op[1:0], operand[15:0], status[15:0]}
    localparam logic [33:0] VEC [NVEC] = '{
        {2'd0, 16'h1234, 16'h0000},
        {2'd1, 16'hBEEF, 16'h0000},
        {2'd2, 16'h0000, 16'hA5C3},
        {2'd1, 16'h0001, 16'h0000},
        {2'd0, 16'hFFFF, 16'h0000},
        {2'd2, 16'h0000, 16'h0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_operand = '0;
    logic        busy, done, error;
    logic [15:0] rd_data, phy_bus;
    logic        cap_addr, cap_data, wr_stb, rd_stb;
    logic        phy_ack = 1'b0;
    logic [15:0] phy_status = '0;

    int checks = 0;
    int failures = 0;
    int phy_mode = 0;          // 0 responsive, 1 dead, 2 stuck high
    int cyc = 0;
    bit finished = 0;

    logic [19:0] trace [8];
    int          tn;
    logic [19:0] last_ev;
    bit          mon_en = 0;
    int          n_done, n_err, busy_cyc, err_cyc;
    bit          err_quiet;

    always #4 clk = ~clk;

    phy_cr_seq #(.INTERVAL(INTERVAL), .MAX_RETRY(MAX_RETRY)) i_phy_cr_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_operand(cmd_operand), .busy(busy), .done(done), .error(error),
        .rd_data(rd_data), .phy_bus(phy_bus), .cap_addr(cap_addr),
        .cap_data(cap_data), .wr_stb(wr_stb), .rd_stb(rd_stb),
        .phy_ack(phy_ack), .phy_status(phy_status)
    );

    // PHY model and monitor, both away from the active edge
    always @(negedge clk) begin
        logic [19:0] ev;
        cyc <= cyc + 1;
        case (phy_mode)
            1:       phy_ack <= 1'b0;
            2:       phy_ack <= 1'b1;
            default: phy_ack <= cap_addr | cap_data | wr_stb | rd_stb;
        endcase
        if (mon_en) begin
            ev = {cap_addr, cap_data, wr_stb, rd_stb, phy_bus};
            if (ev != last_ev && tn < 8) begin
                trace[tn] = ev;
                tn = tn + 1;
            end
            last_ev = ev;
            if (busy && busy_cyc < 0) busy_cyc = cyc;
            if (done) n_done = n_done + 1;
            if (error) begin
                n_err = n_err + 1;
                if (err_cyc < 0) err_cyc = cyc;
                if (busy || phy_bus != 0 || cap_addr || cap_data || wr_stb || rd_stb)
                    err_quiet = 0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_ev(input logic [1:0] op, input logic [15:0] v,
                                          input int i);
        case (op)
            2'd0: case (i)
                0: return {4'b1000, v};
                1: return {4'b0000, v};
                default: return 20'h0;
            endcase
            2'd1: case (i)
                0: return {4'b0100, v};
                1: return {4'b0000, v};
                2: return {4'b0010, v};
                default: return 20'h0;
            endcase
            default: return (i == 0) ? {4'b0001, 16'h0} : 20'h0;
        endcase
    endfunction

    function automatic int exp_len(input logic [1:0] op);
        return (op == 2'd1) ? 4 : (op == 2'd0) ? 3 : 2;
    endfunction

    task automatic run_op(input logic [1:0] op, input logic [15:0] v);
        @(negedge clk);
        tn = 0; last_ev = '0; n_done = 0; n_err = 0;
        busy_cyc = -1; err_cyc = -1; err_quiet = 1; mon_en = 1;
        cmd_op = op; cmd_operand = v; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if ((n_done + n_err) > 0 && !busy) break;
        end
        repeat (4) @(negedge clk);
        mon_en = 0;
    endtask

    task automatic check_trace(input logic [1:0] op, input logic [15:0] v, input string req);
        chk(tn == exp_len(op), req, tn, exp_len(op));
        for (int i = 0; i < exp_len(op) && i < tn; i++)
            chk(trace[i] == exp_ev(op, v, i), req, trace[i], exp_ev(op, v, i));
    endtask

    initial begin
        for (int w = 0; w < 150000; w++) @(posedge clk);
        if (!finished) begin
            failures = failures + 1;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] held;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({busy, done, error, cap_addr, cap_data, wr_stb, rd_stb} == 7'b0, "R1 flags",
            {busy, done, error, cap_addr, cap_data, wr_stb, rd_stb}, 0);
        chk(phy_bus == 0 && rd_data == 0, "R1 buses", {phy_bus, rd_data}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // table walk with a responsive PHY: R2 R3 R4 R9
        for (int n = 0; n < NVEC; n++) begin
            logic [1:0]  op;
            logic [15:0] v, st;
            op = VEC[n][33:32]; v = VEC[n][31:16]; st = VEC[n][15:0];
            held = rd_data;
            phy_status = st;
            run_op(op, v);
            chk(n_done == 1 && n_err == 0, "R9 one done pulse", {n_done, n_err}, 32'h1);
            check_trace(op, v, (op == 2'd0) ? "R2 address phases" :
                               (op == 2'd1) ? "R3 write phases" : "R4 read phases");
            chk(rd_data == ((op == 2'd2) ? st : held), "R4 read data", rd_data,
                (op == 2'd2) ? st : held);
            chk(!busy, "R7 idle after done", busy, 0);
        end

        // R5 R6: dead PHY, write aborts in first step with exact timing
        held = rd_data;
        phy_mode = 1;
        run_op(2'd1, 16'h5A5A);
        chk(n_err == 1 && n_done == 0, "R6 single error", {n_done, n_err}, 32'h1);
        chk((err_cyc - busy_cyc) == MAX_RETRY * INTERVAL + 1, "R5 timeout cycles",
            err_cyc - busy_cyc, MAX_RETRY * INTERVAL + 1);
        chk(err_quiet, "R6 quiet on error", err_quiet, 1);
        chk(tn == 2 && trace[0] == {4'b0100, 16'h5A5A} && trace[1] == 20'h0,
            "R6 no later step", tn, 2);

        // R4: failed read leaves rd_data alone
        phy_status = 16'h7777;
        run_op(2'd2, 16'h0);
        chk(n_err == 1 && rd_data == held, "R4 failed read holds", rd_data, held);

        // R5 R6: acknowledge stuck high, address fails in its release step
        phy_mode = 2;
        repeat (4) @(negedge clk);
        run_op(2'd0, 16'h0C0C);
        chk(n_err == 1 && n_done == 0, "R6 release timeout", {n_done, n_err}, 32'h1);
        check_trace(2'd0, 16'h0C0C, "R5 release wait ran");
        chk(err_cyc - busy_cyc == MAX_RETRY * INTERVAL + 2, "R5 release timeout cycles",
            err_cyc - busy_cyc, MAX_RETRY * INTERVAL + 2);
        phy_mode = 0;
        repeat (4) @(negedge clk);

        // R7: command during busy is ignored
        phy_status = 16'h9999;
        held = rd_data;
        fork
            run_op(2'd1, 16'h2468);
            begin
                repeat (4) @(negedge clk);
                cmd_op = 2'd2; cmd_valid = 1'b1;
                @(negedge clk);
                cmd_valid = 1'b0;
            end
        join
        chk(n_done == 1, "R7 single done", n_done, 1);
        check_trace(2'd1, 16'h2468, "R7 no extra op");
        chk(rd_data == held, "R7 ignored read", rd_data, held);

        // R7: opcode 3 is ignored
        run_op(2'd3, 16'hFFFF);
        chk(busy_cyc < 0 && tn == 0 && n_done == 0, "R7 opcode 3 ignored", tn, 0);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule